// File: doc/BRIEF.md
# Display RAM write address sequencer

This block produces the column and bank address for each byte written into a graphic display memory of 128 columns by 13 banks. Each completed data write moves the address on by one step, so a host can stream pixel bytes without resending addresses. A mode input selects the stepping order. In horizontal order the block walks across the columns of one bank. In vertical order it walks down the banks of one column.

Two programmable limits set the wrap points. The column limit and the bank limit each mark the last index an axis reaches before it returns to zero. A second mode input mirrors the column order at the output only, so the stored counter is never rewritten. Load commands place either counter at a chosen position. A loaded value beyond its limit is clamped to that limit.

Top module: `addr_seq`

## Requirements
- R1: While rst_ni is low, the logical column and bank counters are 0. bank_o reads 0, and col_o reads 0 with mirror_i low or 127 with mirror_i high.
- R2: With vert_i=0, a write (wr_i=1, no load) while the column counter is below col_lim_i adds 1 to the column and leaves the bank unchanged.
- R3: With vert_i=0, a write while the column counter is at or above col_lim_i sets the column to 0. The same write adds 1 to the bank, or sets the bank to 0 if it is at or above the effective bank limit.
- R4: With vert_i=1, a write while the bank counter is below the effective bank limit adds 1 to the bank and leaves the column unchanged.
- R5: With vert_i=1, a write while the bank counter is at or above the effective bank limit sets the bank to 0. The same write adds 1 to the column, or sets the column to 0 if it is at or above col_lim_i.
- R6: col_o equals 127 minus the logical column when mirror_i=1, and equals the logical column when mirror_i=0. Changing mirror_i never alters the logical counter.
- R7: The effective bank limit is bank_lim_i, clamped to 12. The bank output never exceeds 12.
- R8: set_col_i loads col_val_i, clamped to col_lim_i. set_bank_i loads bank_val_i, clamped to the effective bank limit. The loaded value appears on the outputs after the next rising edge.
- R9: In a cycle with set_col_i or set_bank_i high, a write advances neither counter, and an axis that is not loaded keeps its value.
- R10: With wr_i, set_col_i and set_bank_i all low, both counters hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_i | input | 1 | Data write completes on this edge |
| vert_i | input | 1 | 0: step columns first, 1: step banks first |
| mirror_i | input | 1 | Reverse the column order at the output |
| col_lim_i | input | 7 | Last column before wrap |
| bank_lim_i | input | 4 | Last bank before wrap, clamped to 12 |
| set_col_i | input | 1 | Load the column counter |
| col_val_i | input | 7 | Column load value |
| set_bank_i | input | 1 | Load the bank counter |
| bank_val_i | input | 4 | Bank load value |
| col_o | output | 7 | Physical column address |
| bank_o | output | 4 | Bank address |

## Verification
The first directed streams run in both stepping orders at the full 127/12 limits and at small limits. They show whether the inner axis wraps at the right index and carries into the outer axis, and whether the outer axis itself returns to zero. A run with the bank limit set to 15 separates a clamped wrap from an unclamped one. Toggling the mirror input during idle cycles shows that the mapping sits at the output and not in the counter. Load commands are issued above the limits and together with writes, which exposes missing clamps and wrong priority. Random traffic then varies the limits, including limits below the current counter, and mixes in loads and mode changes.

// File: rtl/addr_seq_pkg.sv
package addr_seq_pkg;
  parameter int unsigned NUM_COLS  = 128;
  parameter int unsigned NUM_BANKS = 13;
  localparam int unsigned COL_W  = $clog2(NUM_COLS);
  localparam int unsigned BANK_W = $clog2(NUM_BANKS);
endpackage

// File: rtl/addr_axis_ctr.sv
// One address axis: loadable counter with a programmable wrap limit.
module addr_axis_ctr #(
  parameter int unsigned W   = 4,
  parameter int unsigned MAX = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  input  logic [W-1:0] lim_i,
  input  logic         step_i,
  output logic [W-1:0] val_o,
  output logic         end_o
);
  logic [W-1:0] val_q, eff_lim, ld_val;

  // clamp only when the field can encode values past the array end
  if (MAX < (1 << W) - 1) begin : g_clamp
    assign eff_lim = (lim_i > W'(MAX)) ? W'(MAX) : lim_i;
  end else begin : g_pass
    assign eff_lim = lim_i;
  end

  assign ld_val = (ld_val_i > eff_lim) ? eff_lim : ld_val_i;
  assign end_o  = (val_q >= eff_lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     val_q <= '0;
    else if (ld_i)   val_q <= ld_val;
    else if (step_i) val_q <= end_o ? '0 : val_q + 1'b1;
  end

  assign val_o = val_q;
endmodule

// File: rtl/addr_col_map.sv
// Logical-to-physical column mapping.
module addr_col_map #(
  parameter int unsigned W    = 7,
  parameter int unsigned COLS = 128
) (
  input  logic         mirror_i,
  input  logic [W-1:0] log_i,
  output logic [W-1:0] phys_o
);
  localparam logic [W-1:0] LAST = W'(COLS - 1);
  assign phys_o = mirror_i ? (LAST - log_i) : log_i;
endmodule

// File: rtl/addr_seq.sv
module addr_seq
  import addr_seq_pkg::*;
#(
  parameter int unsigned COLS  = NUM_COLS,
  parameter int unsigned BANKS = NUM_BANKS,
  localparam int unsigned CW   = $clog2(COLS),
  localparam int unsigned BW   = $clog2(BANKS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic          vert_i,
  input  logic          mirror_i,
  input  logic [CW-1:0] col_lim_i,
  input  logic [BW-1:0] bank_lim_i,
  input  logic          set_col_i,
  input  logic [CW-1:0] col_val_i,
  input  logic          set_bank_i,
  input  logic [BW-1:0] bank_val_i,
  output logic [CW-1:0] col_o,
  output logic [BW-1:0] bank_o
);
  logic [CW-1:0] col_q;
  logic [BW-1:0] bank_q;
  logic col_end, bank_end, adv, col_step, bank_step;

  // loads take the cycle; a coincident write does not advance
  assign adv       = wr_i & ~(set_col_i | set_bank_i);
  assign col_step  = vert_i ? (adv & bank_end) : adv;
  assign bank_step = vert_i ? adv : (adv & col_end);

  addr_axis_ctr #(.W(CW), .MAX(COLS - 1)) u_col (
    .clk_i, .rst_ni,
    .ld_i(set_col_i), .ld_val_i(col_val_i), .lim_i(col_lim_i),
    .step_i(col_step), .val_o(col_q), .end_o(col_end)
  );

  addr_axis_ctr #(.W(BW), .MAX(BANKS - 1)) u_bank (
    .clk_i, .rst_ni,
    .ld_i(set_bank_i), .ld_val_i(bank_val_i), .lim_i(bank_lim_i),
    .step_i(bank_step), .val_o(bank_q), .end_o(bank_end)
  );

  addr_col_map #(.W(CW), .COLS(COLS)) u_map (
    .mirror_i, .log_i(col_q), .phys_o(col_o)
  );

  assign bank_o = bank_q;
endmodule

// File: rtl/addr_seq_chk.sv
module addr_seq_chk #(
  parameter int unsigned COLS  = 128,
  parameter int unsigned BANKS = 13,
  localparam int unsigned CW   = $clog2(COLS),
  localparam int unsigned BW   = $clog2(BANKS)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_i,
  input logic          vert_i,
  input logic          mirror_i,
  input logic [CW-1:0] col_lim_i,
  input logic [BW-1:0] bank_lim_i,
  input logic          set_col_i,
  input logic          set_bank_i,
  input logic [CW-1:0] col_o,
  input logic [CW-1:0] col_q,
  input logic [BW-1:0] bank_q
);
  logic          wr_only;
  logic [BW-1:0] y_lim;
  assign wr_only = wr_i & ~set_col_i & ~set_bank_i;
  assign y_lim   = (bank_lim_i > BW'(BANKS - 1)) ? BW'(BANKS - 1) : bank_lim_i;

  // R2
  hz_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_only && !vert_i && col_q < col_lim_i
      |=> col_q == $past(col_q) + 1'b1 && bank_q == $past(bank_q));
  // R3
  hz_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_only && !vert_i && col_q >= col_lim_i |=> col_q == '0);
  // R4
  vt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_only && vert_i && bank_q < y_lim
      |=> bank_q == $past(bank_q) + 1'b1 && col_q == $past(col_q));
  // R5
  vt_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_only && vert_i && bank_q >= y_lim |=> bank_q == '0);
  // R6
  mirror_map_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mirror_i |-> (int'(col_o) + int'(col_q)) == int'(COLS - 1));
  // R7
  bank_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(bank_q) <= int'(BANKS - 1));
  // R8
  ld_clamp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_col_i |=> col_q <= $past(col_lim_i));
  // R9
  ld_prio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_col_i && !set_bank_i |=> bank_q == $past(bank_q));
  // R10
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i && !set_col_i && !set_bank_i |=> $stable(col_q) && $stable(bank_q));
endmodule

bind addr_seq addr_seq_chk #(.COLS(COLS), .BANKS(BANKS)) u_chk (
  .clk_i, .rst_ni, .wr_i, .vert_i, .mirror_i, .col_lim_i, .bank_lim_i,
  .set_col_i, .set_bank_i, .col_o, .col_q, .bank_q
);

// File: tb/sim_addr_seq.sv
`timescale 1ns/1ps
module sim_addr_seq;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_i = 1'b0, vert_i = 1'b0, mirror_i = 1'b0;
  logic [6:0] col_lim_i = 7'd127, col_val_i = '0, col_o;
  logic [3:0] bank_lim_i = 4'd12, bank_val_i = '0, bank_o;
  logic       set_col_i = 1'b0, set_bank_i = 1'b0;

  int checks = 0, errors = 0;
  int mc = 0, mb = 0;   // bench model of the logical counters
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  addr_seq u0 (.*);

  function automatic int ey(int l);
    return (l > 12) ? 12 : l;
  endfunction

  function automatic int exp_col();
    return mirror_i ? 127 - mc : mc;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic model_update();
    int xl = col_lim_i, yl = ey(bank_lim_i);
    if (set_col_i || set_bank_i) begin
      if (set_col_i)  mc = (col_val_i > xl) ? xl : col_val_i;
      if (set_bank_i) mb = (bank_val_i > yl) ? yl : bank_val_i;
    end else if (wr_i) begin
      if (!vert_i) begin
        if (mc >= xl) begin mc = 0; mb = (mb >= yl) ? 0 : mb + 1; end
        else mc++;
      end else begin
        if (mb >= yl) begin mb = 0; mc = (mc >= xl) ? 0 : mc + 1; end
        else mb++;
      end
    end
  endtask

  task automatic step(string tag = "");
    string t = tag;
    if (t == "") begin
      if (set_col_i || set_bank_i) t = wr_i ? "R9" : "R8";
      else if (!wr_i) t = "R10";
      else if (!vert_i) t = (mc >= col_lim_i) ? "R3" : "R2";
      else t = (mb >= ey(bank_lim_i)) ? "R5" : "R4";
    end
    @(posedge clk_i);
    model_update();
    @(negedge clk_i);
    check(t, col_o, exp_col());
    check(t, bank_o, mb);
  endtask

  task automatic writes(int n, string tag = "");
    wr_i = 1'b1;
    for (int i = 0; i < n; i++) step(tag);
    wr_i = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd2024));
    #12;
    check("R1", col_o, 0);
    check("R1", bank_o, 0);
    mirror_i = 1'b1; #1;
    check("R1", col_o, 127);
    mirror_i = 1'b0;
    @(negedge clk_i); rst_ni = 1'b1;

    // horizontal at full limits, across a column wrap
    vert_i = 0; writes(130);
    // horizontal small limits: full bank wrap too
    col_lim_i = 3; bank_lim_i = 2; writes(20);
    // vertical small limits
    vert_i = 1; writes(20);
    // vertical full limits
    col_lim_i = 127; bank_lim_i = 12; writes(30);
    // bank limit above array end
    bank_lim_i = 15; writes(30, "R7");
    vert_i = 0; col_lim_i = 1; writes(40, "R7");
    col_lim_i = 127;
    // mirror toggled while idle
    for (int i = 0; i < 4; i++) begin
      mirror_i = ~mirror_i; step("R6");
    end
    mirror_i = 1'b1; writes(5, "R6"); mirror_i = 1'b0;
    // loads beyond limits
    col_lim_i = 50; col_val_i = 100; set_col_i = 1; step("R8"); set_col_i = 0;
    bank_lim_i = 15; bank_val_i = 14; set_bank_i = 1; step("R8"); set_bank_i = 0;
    col_val_i = 20; set_col_i = 1; step("R8"); set_col_i = 0;
    // load with a coincident write
    col_lim_i = 127; bank_lim_i = 12;
    wr_i = 1; col_val_i = 127; set_col_i = 1; step("R9"); set_col_i = 0; wr_i = 0;
    wr_i = 1; bank_val_i = 5; set_bank_i = 1; step("R9"); set_bank_i = 0; wr_i = 0;
    // idle
    for (int i = 0; i < 3; i++) step("R10");

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      wr_i       = ($urandom % 10) < 7;
      set_col_i  = ($urandom % 20) == 0;
      set_bank_i = ($urandom % 20) == 0;
      col_val_i  = 7'($urandom);
      bank_val_i = 4'($urandom);
      if (($urandom % 50) == 0) vert_i = ~vert_i;
      if (($urandom % 30) == 0) mirror_i = ~mirror_i;
      if (($urandom % 100) == 0) col_lim_i = 7'($urandom);
      if (($urandom % 100) == 0) bank_lim_i = 4'($urandom);
      step();
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule